// File: doc/BRIEF.md
# Serial Bus Port with Attention Acknowledge

This block is the serial-bus side of a peripheral's interface port on an open-collector, three-wire bus. The three lines are attention (ATN), clock (CLK) and data (DATA). Any device may pull a line low and a released line floats high, so each line is the wired-AND of all the devices on it.

The block holds two 8-bit registers: an output register and a direction register. From these, and from the live ATN level, it derives pull-down enables for CLK and DATA. DATA is also gated in hardware by an attention-acknowledge bit: DATA is held low only while the acknowledge bit disagrees with the sensed ATN state. This lets a device answer attention without firmware on the critical path.

A read of the port returns a byte built from two sources. Output-direction bits return the output register. Input-direction bits return the synchronized bus levels, inverted so that a low line reads 1, together with a 2-bit device number taken from address switches. A falling ATN edge sets an interrupt flag. Firmware clears the flag by writing a separate acknowledge register.

Top module: `serial_bus_port`

## Requirements
- R1: After reset the output and direction registers are 0. `clk_pull`, `data_pull` and `atn_irq` are 0.
- R2: `clk_pull` equals output bit 3 AND direction bit 3. Writing 1 to an output-direction bit asserts a pull.
- R3: Let the drive vector be (output AND direction). `data_pull` is 1 exactly when drive bit 1 is 1 and drive bit 4 differs from the asserted-ATN state, where ATN is asserted when the synchronized line is low.
- R4: A bit of `port_rd` whose direction bit is 1 returns the output register bit.
- R5: On input-direction bits, bit 0 reads NOT DATA, bit 2 reads NOT CLK and bit 7 reads NOT ATN, so a low line reads 1. Bits 1, 3 and 4 read 0 when they are inputs.
- R6: Input-direction bits 6 and 5 return `dev_num[1]` and `dev_num[0]`.
- R7: A high-to-low change of `bus_atn` sets `atn_irq` on the third rising clock edge after the change. A low-to-high change sets nothing.
- R8: A write with select 2 clears `atn_irq` at that clock edge. If a falling ATN edge sets the flag on the same edge, the flag stays set.
- R9: Bus lines pass through a two-stage synchronizer, so a line change reaches `port_rd` after the second rising edge.
- R10: Select encoding on writes: 0 is the output register, 1 is the direction register, 2 is acknowledge, and 3 does nothing. No register changes while `wr_en` is 0. A register write is reflected on the outputs right after its clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 output, 1 direction, 2 acknowledge, 3 none |
| wr_data | input | 8 | Write data |
| bus_atn | input | 1 | Sensed ATN line level (1 = high) |
| bus_clk | input | 1 | Sensed CLK line level |
| bus_data | input | 1 | Sensed DATA line level |
| dev_num | input | 2 | Device address switches |
| clk_pull | output | 1 | Pull CLK low |
| data_pull | output | 1 | Pull DATA low |
| port_rd | output | 8 | Port read value |
| atn_irq | output | 1 | Attention interrupt request |

## Verification
A corrupted output or direction register shows at once on `port_rd` for every output-direction bit, and on the two pull enables in the cycle after the write. A synchronizer stage that is wrong or missing moves the edge at which `port_rd` changes and the edge at which `atn_irq` rises by one cycle; the bench checks that timing at each edge. A wrong interrupt flag shows either as a missing request three edges after ATN falls, or as a request that outlives the acknowledge write by a cycle. The same request would also stay set against a rising ATN edge, where it should not appear at all. Because DATA feeds back through the wired-AND bus model, a bad acknowledge gate shows on `port_rd` bit 0 as well as on `data_pull`.

// File: rtl/sbp_pkg.sv
// Package: shared encodings and bit positions for the serial bus port.
// Assumes an 8-bit port; the positions below are fixed by how the bus
// lines and switches are wired onto the port.
package sbp_pkg;
    localparam int PORT_W    = 8;
    localparam int DEV_W     = 2;
    localparam int B_DATA_IN  = 0;
    localparam int B_DATA_OUT = 1;
    localparam int B_CLK_IN   = 2;
    localparam int B_CLK_OUT  = 3;
    localparam int B_ACK_OUT  = 4;
    localparam int B_DEV_LO   = 5;
    localparam int B_ATN_IN   = 7;
    localparam logic [PORT_W-1:0] RD_INVERT = 8'h85;

    typedef enum logic [1:0] {
        SEL_OUT  = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_ACK  = 2'd2,
        SEL_NONE = 2'd3
    } sbp_sel_e;
endpackage

// File: rtl/sbp_sync.sv
// Module: multi-stage synchronizer for asynchronous bus levels.
// Assumes each bit is an independent level; resets to RESET_VAL (released).
module sbp_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw line levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RESET_VAL;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                // Later stages shift the sampled value along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RESET_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sbp_port_regs.sv
// Module: output and direction registers plus the acknowledge strobe.
// Assumes at most one write per cycle; select 3 is a no-op.
module sbp_port_regs
    import sbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  sbp_sel_e          wr_sel,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] out_q,
    output logic [PORT_W-1:0] dir_q,
    output logic              ack_wr
);
    // Register update on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_OUT) out_q <= wr_data;
            if (wr_sel == SEL_DIR) dir_q <= wr_data;
        end
    end

    // Acknowledge strobe for the interrupt flag.
    assign ack_wr = wr_en && (wr_sel == SEL_ACK);
endmodule

// File: rtl/sbp_bus_drive.sv
// Module: derives the CLK and DATA pull-down enables.
// Assumes atn_s is the synchronized ATN level (1 = released high).
module sbp_bus_drive
    import sbp_pkg::*;
(
    input  logic [PORT_W-1:0] out_q,
    input  logic [PORT_W-1:0] dir_q,
    input  logic              atn_s,
    output logic              clk_pull,
    output logic              data_pull
);
    logic [PORT_W-1:0] drv;
    logic              ack_mismatch;

    // Active drive bits and the acknowledge gate for DATA.
    always_comb begin
        drv          = out_q & dir_q;
        ack_mismatch = drv[B_ACK_OUT] ^ ~atn_s;
        clk_pull     = drv[B_CLK_OUT];
        data_pull    = drv[B_DATA_OUT] & ack_mismatch;
    end
endmodule

// File: rtl/sbp_readback.sv
// Module: assembles the port read byte from registers, lines and switches.
// Assumes synchronized line levels; unused input bits read 0.
module sbp_readback
    import sbp_pkg::*;
(
    input  logic [PORT_W-1:0] out_q,
    input  logic [PORT_W-1:0] dir_q,
    input  logic              atn_s,
    input  logic              clk_s,
    input  logic              data_s,
    input  logic [DEV_W-1:0]  dev_num,
    output logic [PORT_W-1:0] port_rd
);
    logic [PORT_W-1:0] status;
    logic [PORT_W-1:0] inputs;

    // Merge line status, inversion mask and switches, then split by direction.
    always_comb begin
        status                      = '0;
        status[B_DATA_IN]           = data_s;
        status[B_CLK_IN]            = clk_s;
        status[B_ATN_IN]            = atn_s;
        inputs                      = status ^ RD_INVERT;
        inputs[B_DEV_LO +: DEV_W]   = dev_num;
        port_rd = (out_q & dir_q) | (inputs & ~dir_q);
    end
endmodule

// File: rtl/sbp_atn_irq.sv
// Module: falling-edge detector on synchronized ATN and interrupt flag.
// Assumes a new edge takes priority over an acknowledge in the same cycle.
module sbp_atn_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic atn_s,
    input  logic ack_wr,
    output logic atn_fall,
    output logic atn_irq
);
    logic atn_prev;

    assign atn_fall = atn_prev & ~atn_s;

    // Track previous ATN and hold the interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            atn_prev <= 1'b1;
            atn_irq  <= 1'b0;
        end else begin
            atn_prev <= atn_s;
            if (atn_fall)    atn_irq <= 1'b1;
            else if (ack_wr) atn_irq <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_bus_port.sv
// Module: top of the serial bus port with attention acknowledge.
// Assumes the wired-AND bus is outside; inputs are sensed line levels.
module serial_bus_port
    import sbp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic        bus_atn,
    input  logic        bus_clk,
    input  logic        bus_data,
    input  logic [1:0]  dev_num,
    output logic        clk_pull,
    output logic        data_pull,
    output logic [7:0]  port_rd,
    output logic        atn_irq
);
    localparam int LINES = 3;

    logic [PORT_W-1:0] out_q;
    logic [PORT_W-1:0] dir_q;
    logic              ack_wr;
    logic [LINES-1:0]  lines_s;
    logic              atn_s;
    logic              clk_s;
    logic              data_s;
    logic              atn_fall;

    sbp_port_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (sbp_sel_e'(wr_sel)),
        .wr_data (wr_data),
        .out_q   (out_q),
        .dir_q   (dir_q),
        .ack_wr  (ack_wr)
    );

    sbp_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_atn, bus_clk, bus_data}),
        .q     (lines_s)
    );

    assign {atn_s, clk_s, data_s} = lines_s;

    sbp_bus_drive u_drive (
        .out_q     (out_q),
        .dir_q     (dir_q),
        .atn_s     (atn_s),
        .clk_pull  (clk_pull),
        .data_pull (data_pull)
    );

    sbp_readback u_rd (
        .out_q   (out_q),
        .dir_q   (dir_q),
        .atn_s   (atn_s),
        .clk_s   (clk_s),
        .data_s  (data_s),
        .dev_num (dev_num),
        .port_rd (port_rd)
    );

    sbp_atn_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .atn_s    (atn_s),
        .ack_wr   (ack_wr),
        .atn_fall (atn_fall),
        .atn_irq  (atn_irq)
    );
endmodule

// File: rtl/sbp_checker.sv
// Module: property checker for the serial bus port, bound to the top.
// Assumes visibility of the top's internal direction, ATN and edge nets.
module sbp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic [7:0] wr_data,
    input logic [1:0] dev_num,
    input logic       clk_pull,
    input logic       data_pull,
    input logic [7:0] port_rd,
    input logic       atn_irq,
    input logic [7:0] dir_q,
    input logic       atn_s,
    input logic       atn_fall
);
    AST_CLK_RELEASED_ON_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && !wr_data[3]) |=> !clk_pull); // R2

    AST_DATA_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_q[1] |-> !data_pull); // R3

    AST_OUT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> ((port_rd & dir_q) == ($past(wr_data) & dir_q))); // R4

    AST_DEV_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q[6:5] == 2'b00) |-> (port_rd[6:5] == dev_num)); // R6

    AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(atn_s) |=> atn_irq); // R7

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(atn_irq) |-> $past(atn_fall)); // R7

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2 && !atn_fall) |=> !atn_irq); // R8
endmodule

bind serial_bus_port sbp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .dev_num   (dev_num),
    .clk_pull  (clk_pull),
    .data_pull (data_pull),
    .port_rd   (port_rd),
    .atn_irq   (atn_irq),
    .dir_q     (dir_q),
    .atn_s     (atn_s),
    .atn_fall  (atn_fall)
);

// File: tb/serial_bus_port_bench.sv
module serial_bus_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = 8'h00;
    logic       host_atn = 1'b1;
    logic       host_clk = 1'b1;
    logic       host_data = 1'b1;
    logic [1:0] dev_num = 2'd2;
    logic       clk_pull;
    logic       data_pull;
    logic [7:0] port_rd;
    logic       atn_irq;
    logic       bus_atn;
    logic       bus_clk;
    logic       bus_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Wired-AND bus: host releases or pulls, the port may pull.
    assign bus_atn  = host_atn;
    assign bus_clk  = host_clk & ~clk_pull;
    assign bus_data = host_data & ~data_pull;

    serial_bus_port u_serial_bus_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .bus_atn   (bus_atn),
        .bus_clk   (bus_clk),
        .bus_data  (bus_data),
        .dev_num   (dev_num),
        .clk_pull  (clk_pull),
        .data_pull (data_pull),
        .port_rd   (port_rd),
        .atn_irq   (atn_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; one rising edge passes with the write strobe high.
    task automatic write_reg(input logic en, input logic [1:0] sel, input logic [7:0] data);
        wr_en = en; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] model_rd(input logic [7:0] o, input logic [7:0] d,
                                            input logic a, input logic c, input logic dt,
                                            input logic [1:0] dv);
        logic [7:0] ins;
        ins = 8'h00;
        ins[0] = ~dt;
        ins[2] = ~c;
        ins[7] = ~a;
        ins[6:5] = dv;
        return (o & d) | (ins & ~d);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] o;
        logic [7:0] drv;
        logic       e_clk;
        logic       e_data;
        logic [7:0] snap;
        settle(3);
        // R1: reset state with all lines released, dev_num 2.
        check("R1 clk_pull", {7'd0, clk_pull}, 8'h00);
        check("R1 data_pull", {7'd0, data_pull}, 8'h00);
        check("R1 irq", {7'd0, atn_irq}, 8'h00);
        rst_n = 1'b1;
        settle(1);
        check("R1 port_rd", port_rd, 8'h40);

        // R2 R3 R4 R5 R6: sweep every direction value against line patterns.
        for (int d = 0; d < 256; d++) begin
            for (int h = 0; h < 8; h++) begin
                host_atn = h[2]; host_clk = h[1]; host_data = h[0];
                dev_num = 2'(d >> 2) ^ 2'(h);
                o = 8'((d * 73 + h * 29 + 5) & 255);
                write_reg(1'b1, 2'd0, o);
                write_reg(1'b1, 2'd1, 8'(d));
                settle(3);
                drv    = o & 8'(d);
                e_clk  = drv[3];
                e_data = drv[1] & (drv[4] ^ ~host_atn);
                check("R2 clk_pull", {7'd0, clk_pull}, {7'd0, e_clk});
                check("R3 data_pull", {7'd0, data_pull}, {7'd0, e_data});
                check("R4 R5 R6 port_rd", port_rd,
                      model_rd(o, 8'(d), host_atn, host_clk & ~e_clk,
                               host_data & ~e_data, dev_num));
            end
        end

        // R9: synchronizer latency on CLK with the port released.
        write_reg(1'b1, 2'd1, 8'h00);
        host_atn = 1'b1; host_clk = 1'b1; host_data = 1'b1; dev_num = 2'd1;
        write_reg(1'b1, 2'd2, 8'h00);
        settle(4);
        check("R9 idle", port_rd, 8'h20);
        host_clk = 1'b0;
        settle(1);
        check("R9 after one edge", port_rd, 8'h20);
        settle(1);
        check("R9 after two edges", port_rd, 8'h24);
        host_clk = 1'b1;
        settle(3);

        // R7: falling ATN sets the flag on the third edge.
        host_atn = 1'b0;
        settle(2);
        check("R7 before third edge", {7'd0, atn_irq}, 8'h00);
        settle(1);
        check("R7 set on third edge", {7'd0, atn_irq}, 8'h01);
        // R8: acknowledge clears.
        write_reg(1'b1, 2'd2, 8'h00);
        check("R8 ack clears", {7'd0, atn_irq}, 8'h00);
        // R7: rising ATN does not set the flag.
        host_atn = 1'b1;
        settle(5);
        check("R7 rising ignored", {7'd0, atn_irq}, 8'h00);
        // R8: edge and acknowledge on the same clock edge, edge wins.
        host_atn = 1'b0;
        settle(2);
        write_reg(1'b1, 2'd2, 8'h00);
        check("R8 edge beats ack", {7'd0, atn_irq}, 8'h01);
        write_reg(1'b1, 2'd2, 8'h00);
        check("R8 later ack clears", {7'd0, atn_irq}, 8'h00);
        host_atn = 1'b1;
        settle(4);

        // R10: writes with wr_en low or select 3 change nothing.
        write_reg(1'b1, 2'd1, 8'hFF);
        write_reg(1'b1, 2'd0, 8'h5A);
        check("R10 write visible", port_rd, 8'h5A);
        snap = port_rd;
        write_reg(1'b0, 2'd0, 8'hA5);
        check("R10 wr_en low", port_rd, snap);
        write_reg(1'b1, 2'd3, 8'h3C);
        check("R10 select 3", port_rd, snap);
        write_reg(1'b0, 2'd1, 8'h00);
        check("R10 dir held", port_rd, snap);
        check("R2 clk_pull from 5A", {7'd0, clk_pull}, 8'h01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule